// File: doc/BRIEF.md
# Power-Down Entry and Wake Sequencer

This block steps a processor core into a dormant low-power state and brings it back out. While the core runs, a level request from the power-down pin or from a software force bit sends the block into the dormant state. It then raises an acknowledge output and, if the configuration asks for it, turns off the oscillator enable. The block leaves the dormant state on a rising edge of the power-down interrupt, which cannot be masked. It then counts a recovery wait before it lets the core run again. An active-low reset ends the dormant state or the wait at any time.

The recovery wait depends on the oscillator. If the oscillator kept running, the wait is short (200 clock cycles by default). If the oscillator was stopped, the wait is long (4096 clock cycles by default) so that the crystal can settle. The oscillator choice is captured when the block enters the dormant state. The context choice is captured at the wake edge. That choice tells the core whether to continue from its saved state or to restart from a cleared one, and it is presented during a single resume cycle that comes before normal running.

Top module: `pwr_dn_seq`

## Requirements
- R1: While reset is held and in the cycles after it is released, `core_run_o` is 1 and `pd_ack_o`, `resume_o` and `ctx_clear_o` are 0, with `osc_en_o` at 1.
- R2: While running, a high level on `pd_pin_i` or on `sw_force_i` at a clock edge moves the block to the dormant state from the next cycle: `pd_ack_o` is 1 and `core_run_o` is 0. A force pulse of one cycle is enough.
- R3: `pd_ack_o` is 1 exactly while the block is dormant. The block stays dormant for any number of cycles until a wake edge arrives.
- R4: `osc_en_o` is 0 only while dormant, and only if `osc_stop_i` was 1 at the entry edge. Changing `osc_stop_i` while dormant affects neither `osc_en_o` nor the wait length.
- R5: If the oscillator was kept running, a wake edge is followed by exactly SHORT_WAIT cycles in which `pd_ack_o`, `core_run_o` and `resume_o` are all 0, and then by the resume cycle.
- R6: If the oscillator was stopped, a wake edge is followed by exactly LONG_WAIT such cycles, and then by the resume cycle.
- R7: Only a 0-to-1 transition of `wake_irq_i` sampled while dormant wakes the block. A level that is already high when the block enters the dormant state does not wake it, and edges that arrive while running have no effect.
- R8: `ctx_clear_o` takes the value of `ctx_clear_i` sampled at the wake edge (1 = cleared context, 0 = keep saved context), is valid in the resume cycle, and holds until the next wake.
- R9: `resume_o` is 1 for exactly one cycle, and `core_run_o` is 1 in the cycle after it.
- R10: Asserting `rst_n` while dormant or during the wait returns the block at once to the running state, with `pd_ack_o` at 0 and `osc_en_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pd_pin_i | input | 1 | Power-down request from the pin, active high, level |
| sw_force_i | input | 1 | Software power-down force bit, active high |
| wake_irq_i | input | 1 | Power-down interrupt, acts on its rising edge |
| osc_stop_i | input | 1 | 1 = stop the oscillator while dormant (long wait), 0 = keep it running (short wait) |
| ctx_clear_i | input | 1 | 1 = restart with a cleared context, 0 = keep the saved context |
| pd_ack_o | output | 1 | Acknowledge, high while dormant |
| osc_en_o | output | 1 | Oscillator enable |
| core_run_o | output | 1 | Core may execute |
| resume_o | output | 1 | One-cycle resume strobe at the end of the wait |
| ctx_clear_o | output | 1 | Context choice for the resume, captured at the wake edge |

## Verification
The assertions assume that `wake_irq_i` is a clean synchronous level, so a rising edge shows up as one sampled 0-to-1 step. They also assume that the power-down requests are dropped by the time the resume cycle ends, because a request that is still high puts the block straight back into the dormant state. The bench changes every input half a cycle away from the active edge. It lowers the requests as soon as entry has been seen and creates wake edges by taking the interrupt low before raising it. Both recovery lengths are measured by counting the cycles in which no state output is high.

// File: rtl/pds_pkg.sv
package pds_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_DOWN   = 2'd1,
    ST_WAKE   = 2'd2,
    ST_RESUME = 2'd3
  } pds_state_e;
endpackage

// File: rtl/pds_rst_sync.sv
module pds_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/pds_trig.sv
module pds_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_pin_i,
  input  logic sw_force_i,
  input  logic wake_irq_i,
  output logic enter_req_o,
  output logic wake_edge_o
);
  logic wake_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_prev_q <= 1'b0;
    else        wake_prev_q <= wake_irq_i;
  end

  assign wake_edge_o = wake_irq_i & ~wake_prev_q;
  assign enter_req_o = pd_pin_i | sw_force_i;
endmodule

// File: rtl/pds_wait_cnt.sv
module pds_wait_cnt #(
  parameter int SHORT_WAIT = 200,
  parameter int LONG_WAIT  = 4096,
  parameter int CNT_W      = $clog2(LONG_WAIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic long_i,
  input  logic count_en_i,
  output logic done_o
);
  localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(SHORT_WAIT - 1);
  localparam logic [CNT_W-1:0] LONG_LOAD  = CNT_W'(LONG_WAIT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = long_i ? LONG_LOAD : SHORT_LOAD;
    end else if (count_en_i && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/pds_fsm.sv
module pds_fsm
  import pds_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enter_req_i,
  input  logic       wake_edge_i,
  input  logic       wait_done_i,
  output logic       load_o,
  output logic       count_en_o,
  output logic       entering_o,
  output pds_state_e state_o
);
  pds_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    entering_o = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (enter_req_i) begin
          state_d    = ST_DOWN;
          entering_o = 1'b1;
        end
      end
      ST_DOWN: begin
        if (wake_edge_i) begin
          state_d = ST_WAKE;
          load_o  = 1'b1;
        end
      end
      ST_WAKE: begin
        if (wait_done_i) state_d = ST_RESUME;
      end
      ST_RESUME: state_d = ST_RUN;
      default:   state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  assign count_en_o = (state_q == ST_WAKE);
  assign state_o    = state_q;
endmodule

// File: rtl/pwr_dn_seq.sv
module pwr_dn_seq
  import pds_pkg::*;
#(
  parameter int SHORT_WAIT = 200,
  parameter int LONG_WAIT  = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_pin_i,
  input  logic sw_force_i,
  input  logic wake_irq_i,
  input  logic osc_stop_i,
  input  logic ctx_clear_i,
  output logic pd_ack_o,
  output logic osc_en_o,
  output logic core_run_o,
  output logic resume_o,
  output logic ctx_clear_o
);
  localparam int CNT_W = $clog2(LONG_WAIT + 1);

  logic       rst_sync_n;
  logic       enter_req, wake_edge, wait_done;
  logic       load, count_en, entering;
  logic       osc_stop_q, ctx_clear_q;
  pds_state_e state;

  pds_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_sync_n)
  );

  pds_trig u_trig (
    .clk(clk), .rst_n(rst_sync_n), .pd_pin_i(pd_pin_i), .sw_force_i(sw_force_i),
    .wake_irq_i(wake_irq_i), .enter_req_o(enter_req), .wake_edge_o(wake_edge)
  );

  pds_wait_cnt #(.SHORT_WAIT(SHORT_WAIT), .LONG_WAIT(LONG_WAIT), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .load_i(load), .long_i(osc_stop_q),
    .count_en_i(count_en), .done_o(wait_done)
  );

  pds_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .enter_req_i(enter_req), .wake_edge_i(wake_edge),
    .wait_done_i(wait_done), .load_o(load), .count_en_o(count_en),
    .entering_o(entering), .state_o(state)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   osc_stop_q <= 1'b0;
    else if (entering) osc_stop_q <= osc_stop_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ctx_clear_q <= 1'b0;
    else if (load)   ctx_clear_q <= ctx_clear_i;
  end

  assign pd_ack_o    = (state == ST_DOWN);
  assign osc_en_o    = !((state == ST_DOWN) && osc_stop_q);
  assign core_run_o  = (state == ST_RUN);
  assign resume_o    = (state == ST_RESUME);
  assign ctx_clear_o = ctx_clear_q;
endmodule

// File: rtl/pds_chk.sv
module pds_chk (
  input logic clk,
  input logic rst_n,
  input logic pd_pin_i,
  input logic sw_force_i,
  input logic wake_irq_i,
  input logic ctx_clear_i,
  input logic pd_ack_o,
  input logic osc_en_o,
  input logic core_run_o,
  input logic resume_o,
  input logic ctx_clear_o
);
  // R3, R9: the state outputs never overlap
  p_state_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pd_ack_o, core_run_o, resume_o}));

  // R2: a request while running leads to the dormant state
  p_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (core_run_o && (pd_pin_i || sw_force_i)) |=> pd_ack_o);

  // R4: the oscillator is only stopped while dormant
  p_osc_only_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en_o |-> pd_ack_o);

  // R4: the oscillator setting holds for the whole dormant period
  p_osc_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_ack_o && $past(pd_ack_o)) |-> $stable(osc_en_o));

  // R3, R7: without a rising edge the block stays dormant
  p_stay_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_ack_o && !(wake_irq_i && !$past(wake_irq_i))) |=> pd_ack_o);

  // R7: a rising edge while dormant starts the wait
  p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_ack_o && $rose(wake_irq_i)) |=> (!pd_ack_o && !core_run_o && !resume_o));

  // R8: the context choice is taken from the wake edge
  p_ctx_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_ack_o && $rose(wake_irq_i)) |=> (ctx_clear_o == $past(ctx_clear_i)));

  // R9: resume lasts one cycle, then the core runs
  p_resume_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resume_o |=> (core_run_o && !resume_o));

  // R8: context output holds through resume
  p_ctx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resume_o |-> $stable(ctx_clear_o));
endmodule

bind pwr_dn_seq pds_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .pd_pin_i(pd_pin_i), .sw_force_i(sw_force_i),
  .wake_irq_i(wake_irq_i), .ctx_clear_i(ctx_clear_i), .pd_ack_o(pd_ack_o),
  .osc_en_o(osc_en_o), .core_run_o(core_run_o), .resume_o(resume_o),
  .ctx_clear_o(ctx_clear_o)
);

// File: tb/sim_pwr_dn_seq.sv
`timescale 1ns/1ps
module sim_pwr_dn_seq;
  localparam int SHORT_W = 200;
  localparam int LONG_W  = 4096;

  logic clk = 1'b0;
  logic rst_n;
  logic pd_pin, sw_force, wake_irq, osc_stop, ctx_clear;
  logic pd_ack, osc_en, core_run, resume, ctx_out;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pwr_dn_seq #(.SHORT_WAIT(SHORT_W), .LONG_WAIT(LONG_W)) u0 (
    .clk(clk), .rst_n(rst_n), .pd_pin_i(pd_pin), .sw_force_i(sw_force),
    .wake_irq_i(wake_irq), .osc_stop_i(osc_stop), .ctx_clear_i(ctx_clear),
    .pd_ack_o(pd_ack), .osc_en_o(osc_en), .core_run_o(core_run),
    .resume_o(resume), .ctx_clear_o(ctx_out)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pd_pin = 0; sw_force = 0; wake_irq = 0; osc_stop = 0; ctx_clear = 0;
    step(3);
    rst_n = 1'b1;
    step(4);
  endtask

  // wake edge, count gap cycles, check resume and context
  task automatic wake_and_measure(input string req, input int exp_len, input int exp_ctx);
    int gap;
    wake_irq = 1'b1;
    step(1);
    gap = 0;
    while (!resume && gap < LONG_W + 10) begin
      if (!pd_ack && !core_run) gap++;
      step(1);
    end
    wake_irq = 1'b0;
    chk(req, "wait cycles", gap, exp_len);
    chk("R8", "ctx_clear_o at resume", int'(ctx_out), exp_ctx);
    chk("R9", "resume pulse", int'(resume), 1);
    step(1);
    chk("R9", "run after resume", int'(core_run), 1);
    chk("R9", "resume one cycle", int'(resume), 0);
    chk("R8", "ctx_clear_o held", int'(ctx_out), exp_ctx);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0; pd_pin = 0; sw_force = 0; wake_irq = 0; osc_stop = 0; ctx_clear = 0;
    step(2);
    chk("R1", "run in reset", int'(core_run), 1);
    chk("R1", "ack in reset", int'(pd_ack), 0);
    chk("R1", "osc_en in reset", int'(osc_en), 1);
    rst_n = 1'b1;
    step(4);
    chk("R1", "run after reset", int'(core_run), 1);
    chk("R1", "resume after reset", int'(resume), 0);
    chk("R1", "ctx after reset", int'(ctx_out), 0);
  endtask

  task automatic t_pin_short();
    osc_stop = 0; ctx_clear = 1; pd_pin = 1;
    step(1);
    pd_pin = 0;
    chk("R2", "ack after pin", int'(pd_ack), 1);
    chk("R2", "run after pin", int'(core_run), 0);
    chk("R4", "osc kept", int'(osc_en), 1);
    step(30);
    chk("R3", "still dormant", int'(pd_ack), 1);
    wake_and_measure("R5", SHORT_W, 1);
  endtask

  task automatic t_force_long();
    osc_stop = 1; ctx_clear = 0; sw_force = 1;
    step(1);
    sw_force = 0;
    chk("R2", "ack after force pulse", int'(pd_ack), 1);
    chk("R4", "osc stopped", int'(osc_en), 0);
    osc_stop = 0;
    step(5);
    chk("R4", "osc cfg change ignored", int'(osc_en), 0);
    wake_and_measure("R6", LONG_W, 0);
    chk("R4", "osc back on", int'(osc_en), 1);
  endtask

  task automatic t_level_no_wake();
    wake_irq = 1; step(3); wake_irq = 0; step(1);
    chk("R7", "edge in run ignored", int'(core_run), 1);
    wake_irq = 1; osc_stop = 0; pd_pin = 1;
    step(1);
    pd_pin = 0;
    step(10);
    chk("R7", "held level no wake", int'(pd_ack), 1);
    wake_irq = 0;
    step(2);
    chk("R7", "falling edge no wake", int'(pd_ack), 1);
    wake_and_measure("R7", SHORT_W, 0);
  endtask

  task automatic t_reset_exit();
    osc_stop = 1; pd_pin = 1;
    step(1);
    pd_pin = 0;
    chk("R10", "dormant before reset", int'(pd_ack), 1);
    #1 rst_n = 1'b0;
    #1;
    chk("R10", "ack cleared by reset", int'(pd_ack), 0);
    chk("R10", "osc on by reset", int'(osc_en), 1);
    step(2);
    rst_n = 1'b1;
    step(3);
    chk("R10", "run after reset exit", int'(core_run), 1);
    sw_force = 1; step(1); sw_force = 0;
    wake_irq = 1; step(20);
    #1 rst_n = 1'b0;
    #1;
    chk("R10", "wait aborted by reset", int'(core_run), 1);
    wake_irq = 0;
    step(2);
    rst_n = 1'b1;
    step(3);
    chk("R10", "running after wait reset", int'(core_run), 1);
  endtask

  initial begin
    t_reset_state();
    t_pin_short();
    t_force_long();
    t_level_no_wake();
    do_reset();
    t_reset_exit();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule